// File: doc/BRIEF.md
# Receive Carrier Sense with Post-Transmit Blanking

This block sits between a receive bit decoder and a MAC and produces the carrier-sense signal. It runs on the 20 MHz system clock. Decoded receive bits arrive with a one-cycle valid strobe, one per 100 ns bit time. An activity input marks the times when the line front end sees a signal. Carrier-sense rises once four successive captured bits alternate. It falls once activity has been absent for a set number of bit strobes.

When the attachment-unit port is the active port, the external transceiver sends a short 10 MHz test burst on its collision pair after each transmission. This burst must not be read as receive traffic. So on every falling edge of transmit-enable with that port selected, the block opens a blanking window of a fixed number of clock cycles. The window covers the latest burst start plus the longest burst. While the window is open, carrier-sense is held off and the captured bits are discarded. With the twisted-pair port selected, no window opens.

A three-state machine drives carrier-sense. The states are `ST_IDLE`, `ST_CARRIER` and `ST_BLANK`, and they have these transitions:
- IDLE→CARRIER on a pattern match.
- IDLE→BLANK and CARRIER→BLANK when the blanking window opens.
- CARRIER→IDLE after the idle-strobe count is reached.
- BLANK→IDLE when the window closes.

Top module: `carrier_sense_unit`

## Requirements
- R1: During and straight after reset, `crs` and `blank_act` are 0, the captured bits are empty and the blanking timer is stopped.
- R2: With `rx_active` high and no blanking, `crs` goes to 1 one clock after the strobe edge that captures the fourth bit of the time-ordered sequence 1,0,1,0. The bits shift into the window newest-last, so the oldest bit is the leftmost bit of the pattern.
- R3: The time-ordered sequence 0,1,0,1 asserts `crs` with the same timing as R2.
- R4: Any four-bit window that does not alternate (for example 1,1,0,0 or 1,0,0,1) leaves `crs` at 0.
- R5: A cycle with `rx_active` low empties the captured bits. A match then needs four new bits, and bits captured before the drop never count toward it.
- R6: `crs` falls one clock after the second bit strobe seen with `rx_active` continuously low. A single low strobe leaves `crs` at 1.
- R7: With `port_aui` = 1, a falling edge of `tx_en` sets `blank_act` to 1 from the next cycle, for exactly `BLANK_CYCLES` (default 62) clock cycles.
- R8: With `port_aui` = 0, a falling edge of `tx_en` leaves `blank_act` at 0.
- R9: While `blank_act` is 1, captured bits are discarded and `crs` stays 0. After the window closes, four fresh alternating bits are needed to assert `crs`.
- R10: If `crs` is 1 when the window opens, `crs` falls one clock after `blank_act` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Decoded receive bit |
| rx_bit_vld | input | 1 | One-cycle strobe per bit time qualifying `rx_bit` |
| rx_active | input | 1 | Line activity seen by the front end |
| tx_en | input | 1 | Transmit enable from the MAC |
| port_aui | input | 1 | 1 = attachment-unit port, 0 = twisted-pair port |
| crs | output | 1 | Carrier sense to the MAC |
| blank_act | output | 1 | Post-transmit blanking window open |

## Verification
The assertions assume the following about the inputs:
- `tx_en` and `port_aui` change only between clock edges, and `port_aui` stays constant around each transmit-enable fall.
- The bit strobe keeps ticking once per bit time even while `rx_active` is low, so the idle count can advance.

The bench drives every input on the falling clock edge. It spaces bit strobes two cycles apart and emits idle strobes whenever it wants carrier to drop. It holds the port select steady for the whole of each transmit pulse and the blanking window that follows.

// File: rtl/csd_pkg.sv
package csd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CARRIER = 2'd1,
        ST_BLANK   = 2'd2
    } csd_state_e;
endpackage

// File: rtl/csd_pattern_shift.sv
// Captures qualified receive bits and flags an alternating window of PAT_LEN bits.
module csd_pattern_shift #(
    parameter int PAT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic clear,
    output logic match
);
    localparam int FILL_W = $clog2(PAT_LEN + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PAT_LEN);

    logic [PAT_LEN-1:0] win_q;
    logic [FILL_W-1:0]  fill_q;
    logic [PAT_LEN-1:0] alt_even;
    logic [PAT_LEN-1:0] alt_odd;

    // newest bit in position 0; alt_even ends in 0, alt_odd ends in 1
    for (genvar i = 0; i < PAT_LEN; i++) begin : g_alt
        assign alt_even[i] = (i % 2) == 1;
        assign alt_odd[i]  = (i % 2) == 0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (bit_vld) begin
            win_q <= {win_q[PAT_LEN-2:0], bit_in};
            if (fill_q != FILL_MAX) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    assign match = (fill_q == FILL_MAX) && ((win_q == alt_even) || (win_q == alt_odd));
endmodule

// File: rtl/csd_idle_count.sv
// Counts bit strobes seen while line activity is absent.
module csd_idle_count #(
    parameter int DROP_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic active,
    output logic idle_done
);
    localparam int CNT_W = $clog2(DROP_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DROP_BITS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || active) begin
            cnt_q <= '0;
        end else if (bit_vld && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle_done = (cnt_q == CNT_MAX);
endmodule

// File: rtl/csd_blank_timer.sv
// Opens a fixed-length window on each transmit-enable fall on the attachment-unit port.
module csd_blank_timer #(
    parameter int BLANK_CYCLES = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic port_aui,
    output logic blank_act
);
    localparam int TMR_W = $clog2(BLANK_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(BLANK_CYCLES);

    logic             tx_q;
    logic [TMR_W-1:0] tmr_q;
    logic             tx_fall;

    assign tx_fall = tx_q && !tx_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= 1'b0;
            tmr_q <= '0;
        end else begin
            tx_q <= tx_en;
            if (tx_fall && port_aui) begin
                tmr_q <= TMR_LOAD;
            end else if (tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    assign blank_act = (tmr_q != '0);
endmodule

// File: rtl/carrier_sense_unit.sv
module carrier_sense_unit
    import csd_pkg::*;
#(
    parameter int PAT_LEN      = 4,
    parameter int DROP_BITS    = 2,
    parameter int BLANK_CYCLES = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_bit_vld,
    input  logic rx_active,
    input  logic tx_en,
    input  logic port_aui,
    output logic crs,
    output logic blank_act
);
    csd_state_e state_q, state_d;
    logic       pat_match;
    logic       idle_done;
    logic       shift_clear;

    assign shift_clear = !rx_active || blank_act;

    csd_pattern_shift #(.PAT_LEN(PAT_LEN)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (rx_bit),
        .bit_vld (rx_bit_vld),
        .clear   (shift_clear),
        .match   (pat_match)
    );

    csd_idle_count #(.DROP_BITS(DROP_BITS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (rx_bit_vld),
        .active    (rx_active),
        .idle_done (idle_done)
    );

    csd_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .port_aui  (port_aui),
        .blank_act (blank_act)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (blank_act)      state_d = ST_BLANK;
                else if (pat_match) state_d = ST_CARRIER;
            end
            ST_CARRIER: begin
                if (blank_act)      state_d = ST_BLANK;
                else if (idle_done) state_d = ST_IDLE;
            end
            ST_BLANK: begin
                if (!blank_act)     state_d = ST_IDLE;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        crs = (state_q == ST_CARRIER);
    end
endmodule

// File: rtl/carrier_sense_unit_chk.sv
module carrier_sense_unit_chk #(
    parameter int BLANK_CYCLES = 62
) (
    input logic clk,
    input logic rst_n,
    input logic rx_active,
    input logic tx_en,
    input logic port_aui,
    input logic crs,
    input logic blank_act
);
    localparam int RUN_W = $clog2(BLANK_CYCLES + 2);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(BLANK_CYCLES);
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(BLANK_CYCLES + 1);

    logic             tx_prev;
    logic [RUN_W-1:0] run_q;
    logic             load_ev;

    assign load_ev = tx_prev && !tx_en && port_aui;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_prev <= 1'b0;
            run_q   <= '0;
        end else begin
            tx_prev <= tx_en;
            if (load_ev)                         run_q <= RUN_W'(1);
            else if (blank_act && run_q != '1)   run_q <= run_q + 1'b1;
            else if (!blank_act)                 run_q <= '0;
        end
    end

    // R7
    blank_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ev |=> blank_act);

    // R7
    blank_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act |-> (run_q <= RUN_LIM));

    // R7
    blank_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank_act) |-> (run_q == RUN_END));

    // R8
    tp_no_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_act && !port_aui) |=> !blank_act);

    // R10
    blank_kills_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act |=> !crs);

    // R2
    crs_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs) |-> ($past(rx_active) && !$past(blank_act)));
endmodule

bind carrier_sense_unit carrier_sense_unit_chk #(.BLANK_CYCLES(BLANK_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_active (rx_active),
    .tx_en     (tx_en),
    .port_aui  (port_aui),
    .crs       (crs),
    .blank_act (blank_act)
);

// File: tb/tb_carrier_sense_unit.sv
module tb_carrier_sense_unit;
    localparam int CLK_PERIOD = 50;
    localparam int BLANK      = 62;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic rx_bit_vld = 1'b0;
    logic rx_active = 1'b0;
    logic tx_en = 1'b0;
    logic port_aui = 1'b0;
    logic crs;
    logic blank_act;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    carrier_sense_unit #(.BLANK_CYCLES(BLANK)) dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .rx_active(rx_active), .tx_en(tx_en), .port_aui(port_aui),
        .crs(crs), .blank_act(blank_act)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rx_active = 1'b1; rx_bit = b; rx_bit_vld = 1'b1;
        tick();
        rx_bit_vld = 1'b0;
        tick();
    endtask

    task automatic idle_bit();
        rx_active = 1'b0; rx_bit_vld = 1'b1;
        tick();
        rx_bit_vld = 1'b0;
        tick();
    endtask

    task automatic settle();
        idle_bit(); idle_bit();
        repeat (2) tick();
    endtask

    task automatic tx_pulse(input logic aui);
        port_aui = aui; tx_en = 1'b1;
        repeat (5) tick();
        tx_en = 1'b0;
        tick();
    endtask

    task automatic wait_blank_end();
        for (int i = 0; i < 100 && blank_act; i++) tick();
    endtask

    task automatic t_reset();
        check(crs == 1'b0, "R1 crs in reset", int'(crs), 0);
        check(blank_act == 1'b0, "R1 blank in reset", int'(blank_act), 0);
        rst_n = 1'b1;
        tick();
        check(crs == 1'b0, "R1 crs after reset", int'(crs), 0);
        check(blank_act == 1'b0, "R1 blank after reset", int'(blank_act), 0);
    endtask

    task automatic t_pattern_1010();
        send_bit(1); send_bit(0); send_bit(1);
        check(crs == 1'b0, "R2 three bits", int'(crs), 0);
        send_bit(0);
        check(crs == 1'b1, "R2 1010 asserts", int'(crs), 1);
        settle();
    endtask

    task automatic t_pattern_0101();
        send_bit(0); send_bit(1); send_bit(0);
        check(crs == 1'b0, "R3 three bits", int'(crs), 0);
        send_bit(1);
        check(crs == 1'b1, "R3 0101 asserts", int'(crs), 1);
        settle();
    endtask

    task automatic t_non_alt();
        send_bit(1); send_bit(1); send_bit(0); send_bit(0);
        send_bit(1); send_bit(1); send_bit(1); send_bit(1);
        check(crs == 1'b0, "R4 non-alternating", int'(crs), 0);
        settle();
    endtask

    task automatic t_stale_clear();
        send_bit(1); send_bit(0);
        rx_active = 1'b0;
        tick();
        send_bit(1); send_bit(0);
        check(crs == 1'b0, "R5 stale bits discarded", int'(crs), 0);
        send_bit(1); send_bit(0);
        check(crs == 1'b1, "R5 four fresh bits", int'(crs), 1);
        settle();
    endtask

    task automatic t_idle_drop();
        send_bit(0); send_bit(1); send_bit(0); send_bit(1);
        idle_bit();
        check(crs == 1'b1, "R6 one idle strobe keeps crs", int'(crs), 1);
        idle_bit();
        check(crs == 1'b0, "R6 two idle strobes drop crs", int'(crs), 0);
        settle();
    endtask

    task automatic t_blank_len();
        int highs;
        tx_pulse(1'b1);
        check(blank_act == 1'b1, "R7 window opens", int'(blank_act), 1);
        highs = 0;
        for (int i = 0; i < BLANK + 10; i++) begin
            if (blank_act) highs++;
            tick();
        end
        check(highs == BLANK, "R7 window length", highs, BLANK);
        settle();
    endtask

    task automatic t_tp_no_blank();
        int highs;
        tx_pulse(1'b0);
        highs = 0;
        for (int i = 0; i < BLANK + 10; i++) begin
            if (blank_act) highs++;
            tick();
        end
        check(highs == 0, "R8 twisted pair no window", highs, 0);
        settle();
    endtask

    task automatic t_blank_ignore();
        tx_pulse(1'b1);
        send_bit(1); send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        check(crs == 1'b0, "R9 bits ignored in window", int'(crs), 0);
        wait_blank_end();
        check(blank_act == 1'b0, "R9 window closed", int'(blank_act), 0);
        send_bit(1); send_bit(0); send_bit(1);
        check(crs == 1'b0, "R9 three fresh bits", int'(crs), 0);
        send_bit(0);
        check(crs == 1'b1, "R9 four fresh bits", int'(crs), 1);
        settle();
    endtask

    task automatic t_blank_kills();
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        check(crs == 1'b1, "R10 carrier up", int'(crs), 1);
        tx_pulse(1'b1);
        check(blank_act == 1'b1, "R10 window open", int'(blank_act), 1);
        tick();
        check(crs == 1'b0, "R10 crs forced off", int'(crs), 0);
        wait_blank_end();
        settle();
    endtask

    initial begin
        repeat (4) tick();
        t_reset();
        t_pattern_1010();
        t_pattern_0101();
        t_non_alt();
        t_stale_clear();
        t_idle_drop();
        t_blank_len();
        t_tp_no_blank();
        t_blank_ignore();
        t_blank_kills();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule